// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 30-bit physical address. It reads a two-level page table that sits in a byte-addressed memory. A request carries the virtual address and the byte address of the top-level table. The walker then issues one or two entry reads on a memory port with a request/ready handshake. It returns the frame number, the six status bits of the entry that ended the walk, the physical address and a fault flag.

The address splits into two 10-bit table indices and a 12-bit page offset. The offset is never translated. Entries are three bytes wide, so entry `i` of a table at byte address `B` lives at `B + 3*i`. A top-level entry points to a second-level table. A second-level entry names the 4 KB frame. If the valid bit is clear at either level, the walk stops at once and reports a fault.

Top module: `pt2_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req_valid` are all 0.
- R2: The first read goes to address `req_root + 3*vaddr[31:22]`, truncated to 30 bits.
- R3: If the first entry is valid, the second read goes to address `(entry1[23:6] << 12) + 3*vaddr[21:12]`.
- R4: Entries use this layout: bits [23:6] hold the frame number and bits [5:0] hold status. Status bit 0 is valid, bit 1 dirty, bit 2 read, bit 3 write and bit 4 execute. On a successful walk, `rsp_ppn` is entry2[23:6] and `rsp_status` is entry2[5:0], with the dirty and permission bits copied unchanged. `rsp_paddr` is `{rsp_ppn, vaddr[11:0]}` and `rsp_fault` is 0.
- R5: A first-level entry with bit 0 clear raises `done` with `rsp_fault`=1 in the cycle after its response, and the walk makes no second read. `rsp_ppn` and `rsp_status` then show that entry's fields.
- R6: A second-level entry with bit 0 clear raises `done` with `rsp_fault`=1 in the cycle after its response, and the outputs show that entry's fields.
- R7: `done` is a one-cycle pulse and is followed by the idle state. `busy` is 1 from the cycle after a request is accepted through the `done` cycle.
- R8: While `mem_req_ready` is 0, `mem_req_valid` and `mem_req_addr` stay unchanged. A response is accepted after any number of wait cycles.
- R9: `req_valid` is ignored while `busy` is 1. The walk in progress completes with its own results and its own reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 30 | Byte address of the top-level table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 30 | Frame number joined with page offset |
| rsp_ppn | output | 18 | Frame field of the final entry |
| rsp_status | output | 6 | Status field of the final entry |
| rsp_fault | output | 1 | Page fault (invalid entry met) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 30 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 24 | Three-byte entry |

## Verification
The bench targets the extreme index values (0 and 1023) and non-zero offsets. A walker that scales the index by 4 instead of 3, or takes the wrong index field, reads the wrong address. Invalid entries are placed at each level. A walker that keeps reading after a fault shows an extra read. A walker that checks validity at only one level returns a frame marked as good when it should fault. Stalled request acceptance and long response latencies catch a request that drops early or a response taken too soon. A second request fired in the middle of a walk catches a walker that restarts or mixes up its captured address.

// File: rtl/pt2_walker_pkg.sv
package pt2_walker_pkg;
   typedef enum logic [2:0] {
      WK_IDLE    = 3'd0,
      WK_L1_REQ  = 3'd1,
      WK_L1_WAIT = 3'd2,
      WK_L2_REQ  = 3'd3,
      WK_L2_WAIT = 3'd4,
      WK_DONE    = 3'd5
   } wk_state_e;

   localparam int ST_VALID_BIT = 0;
   localparam int ST_DIRTY_BIT = 1;
   localparam int ST_READ_BIT  = 2;
   localparam int ST_WRITE_BIT = 3;
   localparam int ST_EXEC_BIT  = 4;
endpackage

// File: rtl/pt2_entry_addr.sv
module pt2_entry_addr #(
   parameter int IDX_W     = 10,
   parameter int PA_W      = 30,
   parameter int ENT_BYTES = 3
) (
   input  logic [PA_W-1:0]  tbl_base,
   input  logic [IDX_W-1:0] tbl_idx,
   output logic [PA_W-1:0]  ent_addr
);
   logic [PA_W-1:0] idx_ext;
   logic [PA_W-1:0] scaled;

   assign idx_ext = PA_W'(tbl_idx);

   generate
      if (ENT_BYTES == 3) begin : g_shift_add
         assign scaled = (idx_ext << 1) + idx_ext;
      end else if ((ENT_BYTES & (ENT_BYTES - 1)) == 0) begin : g_shift
         assign scaled = idx_ext << $clog2(ENT_BYTES);
      end else begin : g_mult
         assign scaled = idx_ext * PA_W'(ENT_BYTES);
      end
   endgenerate

   assign ent_addr = tbl_base + scaled;
endmodule

// File: rtl/pt2_entry_dec.sv
module pt2_entry_dec #(
   parameter int PPN_W = 18,
   parameter int ST_W  = 6,
   localparam int ENT_W = PPN_W + ST_W
) (
   input  logic [ENT_W-1:0] entry,
   output logic [PPN_W-1:0] ent_ppn,
   output logic [ST_W-1:0]  ent_status,
   output logic             ent_valid
);
   import pt2_walker_pkg::*;

   assign ent_ppn    = entry[ENT_W-1:ST_W];
   assign ent_status = entry[ST_W-1:0];
   assign ent_valid  = entry[ST_VALID_BIT];
endmodule

// File: rtl/pt2_walker.sv
module pt2_walker #(
   parameter int IDX_W     = 10,
   parameter int OFF_W     = 12,
   parameter int PPN_W     = 18,
   parameter int ST_W      = 6,
   parameter int ENT_BYTES = 3,
   localparam int VA_W  = 2 * IDX_W + OFF_W,
   localparam int PA_W  = PPN_W + OFF_W,
   localparam int ENT_W = PPN_W + ST_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [PA_W-1:0]  req_root,
   output logic             busy,
   output logic             done,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic [PPN_W-1:0] rsp_ppn,
   output logic [ST_W-1:0]  rsp_status,
   output logic             rsp_fault,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [ENT_W-1:0] mem_rsp_data
);
   import pt2_walker_pkg::*;

   localparam int HI_LSB = OFF_W + IDX_W;

   generate
      if (ENT_W != 8 * ENT_BYTES) begin : g_bad_entry
         $error("entry width does not match entry byte count");
      end
      if (ST_W < 5) begin : g_bad_status
         $error("status field too narrow for valid, dirty and permissions");
      end
      if (IDX_W < 1 || OFF_W < 1) begin : g_bad_split
         $error("index and offset widths must be positive");
      end
   endgenerate

   wk_state_e        state_q, state_d;
   logic [VA_W-1:0]  vaddr_q;
   logic [PA_W-1:0]  root_q;
   logic [PA_W-1:0]  l2base_q;
   logic [PPN_W-1:0] ppn_q;
   logic [ST_W-1:0]  st_q;
   logic             fault_q;

   logic             at_l1;
   logic [PA_W-1:0]  sel_base;
   logic [IDX_W-1:0] sel_idx;
   logic [PPN_W-1:0] dec_ppn;
   logic [ST_W-1:0]  dec_st;
   logic             dec_valid;

   assign at_l1    = (state_q == WK_L1_REQ) || (state_q == WK_L1_WAIT);
   assign sel_base = at_l1 ? root_q : l2base_q;
   assign sel_idx  = at_l1 ? vaddr_q[VA_W-1:HI_LSB] : vaddr_q[HI_LSB-1:OFF_W];

   pt2_entry_addr #(
      .IDX_W(IDX_W), .PA_W(PA_W), .ENT_BYTES(ENT_BYTES)
   ) u_addr (
      .tbl_base(sel_base),
      .tbl_idx (sel_idx),
      .ent_addr(mem_req_addr)
   );

   pt2_entry_dec #(
      .PPN_W(PPN_W), .ST_W(ST_W)
   ) u_dec (
      .entry     (mem_rsp_data),
      .ent_ppn   (dec_ppn),
      .ent_status(dec_st),
      .ent_valid (dec_valid)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WK_IDLE:    if (req_valid) state_d = WK_L1_REQ;
         WK_L1_REQ:  if (mem_req_ready) state_d = WK_L1_WAIT;
         WK_L1_WAIT: if (mem_rsp_valid) state_d = dec_valid ? WK_L2_REQ : WK_DONE;
         WK_L2_REQ:  if (mem_req_ready) state_d = WK_L2_WAIT;
         WK_L2_WAIT: if (mem_rsp_valid) state_d = WK_DONE;
         WK_DONE:    state_d = WK_IDLE;
         default:    state_d = WK_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= WK_IDLE;
         vaddr_q  <= '0;
         root_q   <= '0;
         l2base_q <= '0;
         ppn_q    <= '0;
         st_q     <= '0;
         fault_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == WK_IDLE && req_valid) begin
            vaddr_q <= req_vaddr;
            root_q  <= req_root;
         end
         if (state_q == WK_L1_WAIT && mem_rsp_valid) begin
            l2base_q <= {dec_ppn, {OFF_W{1'b0}}};
            if (!dec_valid) begin
               ppn_q   <= dec_ppn;
               st_q    <= dec_st;
               fault_q <= 1'b1;
            end
         end
         if (state_q == WK_L2_WAIT && mem_rsp_valid) begin
            ppn_q   <= dec_ppn;
            st_q    <= dec_st;
            fault_q <= !dec_valid;
         end
      end
   end

   assign busy          = (state_q != WK_IDLE);
   assign done          = (state_q == WK_DONE);
   assign mem_req_valid = (state_q == WK_L1_REQ) || (state_q == WK_L2_REQ);
   assign rsp_ppn       = ppn_q;
   assign rsp_status    = st_q;
   assign rsp_fault     = fault_q;
   assign rsp_paddr     = {ppn_q, vaddr_q[OFF_W-1:0]};
endmodule

// File: rtl/pt2_walker_chk.sv
module pt2_walker_chk #(
   parameter int PA_W = 30,
   parameter int ST_W = 6
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       busy,
   input logic                       done,
   input logic                       rsp_fault,
   input logic [ST_W-1:0]            rsp_status,
   input logic                       mem_req_valid,
   input logic                       mem_req_ready,
   input logic [PA_W-1:0]            mem_req_addr,
   input logic                       mem_rsp_valid,
   input logic                       rsp_ent_valid,
   input pt2_walker_pkg::wk_state_e  state
);
   import pt2_walker_pkg::*;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   // R7
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R5
   l1_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WK_L1_WAIT && mem_rsp_valid && !rsp_ent_valid)
         |=> (done && rsp_fault && !mem_req_valid));

   // R6
   l2_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WK_L2_WAIT && mem_rsp_valid && !rsp_ent_valid) |=> (done && rsp_fault));

   // R4
   good_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rsp_fault) |-> rsp_status[ST_VALID_BIT]);
endmodule

bind pt2_walker pt2_walker_chk #(.PA_W(PA_W), .ST_W(ST_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .done         (done),
   .rsp_fault    (rsp_fault),
   .rsp_status   (rsp_status),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_addr (mem_req_addr),
   .mem_rsp_valid(mem_rsp_valid),
   .rsp_ent_valid(mem_rsp_data[0]),
   .state        (state_q)
);

// File: tb/pt2_walker_tb_top.sv
`timescale 1ns/1ps
module pt2_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [29:0] req_root = '0;
   logic        busy, done, rsp_fault, mem_req_valid;
   logic [29:0] rsp_paddr, mem_req_addr;
   logic [17:0] rsp_ppn;
   logic [5:0]  rsp_status;
   logic        mem_req_ready = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [23:0] mem_rsp_data = '0;

   always #2 clk = ~clk;

   pt2_walker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_root(req_root), .busy(busy), .done(done), .rsp_paddr(rsp_paddr),
      .rsp_ppn(rsp_ppn), .rsp_status(rsp_status), .rsp_fault(rsp_fault),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data)
   );

   typedef struct {
      logic [17:0] ppn;
      logic [5:0]  st;
      logic        flt;
      logic [29:0] pa;
      int          reads;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   logic [29:0] addr_q[$];
   string       addr_tag_q[$];
   logic [23:0] pt [logic [29:0]];

   int total = 0, bad = 0;
   int lat_cfg = 0, stall_cfg = 0;
   int reads_seen = 0, n_done = 0;
   bit finished = 0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] rd(logic [29:0] a);
      return pt.exists(a) ? pt[a] : 24'h0;
   endfunction

   function automatic logic [29:0] ent_at(logic [29:0] base, logic [9:0] idx);
      return base + 30'(idx) * 30'd3;
   endfunction

   // Memory responder: checks each read address against the scoreboard.
   initial begin
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (rst_n && mem_req_valid) begin
            for (int s = 0; s < stall_cfg; s++) begin
               mem_req_ready = 1'b0;
               @(negedge clk);
            end
            mem_req_ready = 1'b1;
            reads_seen++;
            if (addr_q.size() == 0) begin
               chk("R5 extra read", 64'(mem_req_addr), 64'h0);
               mem_rsp_data = rd(mem_req_addr);
            end else begin
               chk(addr_tag_q.pop_front(), 64'(mem_req_addr), 64'(addr_q.pop_front()));
               mem_rsp_data = rd(mem_req_addr);
            end
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (lat_cfg) @(negedge clk);
            mem_rsp_valid = 1'b1;
         end
      end
   end

   // Result monitor.
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            exp_t e;
            if (exp_q.size() == 0) begin
               chk("R7 unexpected done", 64'd1, 64'd0);
            end else begin
               e = exp_q.pop_front();
               chk({e.tag, " R4 ppn"},    64'(rsp_ppn),    64'(e.ppn));
               chk({e.tag, " R4 status"}, 64'(rsp_status), 64'(e.st));
               chk({e.tag, " R4 paddr"},  64'(rsp_paddr),  64'(e.pa));
               chk({e.tag, " fault"},     64'(rsp_fault),  64'(e.flt));
               chk({e.tag, " read count"}, 64'(reads_seen), 64'(e.reads));
            end
            @(negedge clk);
            chk("R7 done pulse width", 64'(done), 64'd0);
            chk("R7 idle after done", 64'(busy), 64'd0);
            reads_seen = 0;
            n_done++;
         end
      end
   end

   task automatic walk(logic [31:0] va, logic [29:0] root, string tag, bit interfere);
      exp_t        e;
      logic [29:0] a1, a2;
      logic [23:0] e1, e2;
      int          prev;
      a1 = ent_at(root, va[31:22]);
      e1 = rd(a1);
      addr_q.push_back(a1);
      addr_tag_q.push_back({tag, " R2 L1 addr"});
      e.tag = tag;
      if (!e1[0]) begin
         e.ppn = e1[23:6]; e.st = e1[5:0]; e.flt = 1'b1; e.reads = 1;
      end else begin
         a2 = ent_at({e1[23:6], 12'h000}, va[21:12]);
         e2 = rd(a2);
         addr_q.push_back(a2);
         addr_tag_q.push_back({tag, " R3 L2 addr"});
         e.ppn = e2[23:6]; e.st = e2[5:0]; e.flt = !e2[0]; e.reads = 2;
      end
      e.pa = {e.ppn, va[11:0]};
      exp_q.push_back(e);
      prev = n_done;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_root = root;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " R7 busy"}, 64'(busy), 64'd1);
      if (interfere) begin
         // R9: a second request while busy must be ignored
         req_valid = 1'b1; req_vaddr = ~va; req_root = root + 30'd300;
         @(negedge clk);
         req_valid = 1'b0; req_vaddr = va; req_root = root;
      end
      while (n_done == prev) @(negedge clk);
   endtask

   task automatic set_l1(logic [29:0] root, logic [9:0] i, logic [17:0] tbl, logic [5:0] st);
      pt[ent_at(root, i)] = {tbl, st};
   endtask

   task automatic set_l2(logic [17:0] tbl, logic [9:0] i, logic [17:0] ppn, logic [5:0] st);
      pt[ent_at({tbl, 12'h000}, i)] = {ppn, st};
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [29:0] root_a, root_b;
      root_a = 30'h0001_0000;
      root_b = 30'h3FFF_F000;
      // Table contents
      set_l1(root_a, 10'd1,    18'h00020, 6'b000001);
      set_l2(18'h00020, 10'd3,    18'h2ABCD, 6'b001111);
      set_l2(18'h00020, 10'd1023, 18'h3FFFF, 6'b011111);
      set_l2(18'h00020, 10'd0,    18'h00001, 6'b000001);
      set_l2(18'h00020, 10'd5,    18'h12345, 6'b011110);
      set_l1(root_a, 10'd2,    18'h00777, 6'b011110);
      set_l1(root_a, 10'd1023, 18'h00031, 6'b000011);
      set_l2(18'h00031, 10'd1023, 18'h15555, 6'b010101);
      set_l1(root_b, 10'd0,    18'h00040, 6'b000001);
      set_l2(18'h00040, 10'd512, 18'h0F0F0, 6'b000111);

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", 64'(busy), 64'd0);
      chk("R1 done after reset", 64'(done), 64'd0);
      chk("R1 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);

      walk(32'h0040_3ABC, root_a, "R4 basic", 0);
      walk(32'h007F_F001, root_a, "R4 max idx2", 0);
      walk(32'h0040_0FFF, root_a, "R4 idx2 zero", 0);
      walk(32'h0080_1234, root_a, "R5 L1 invalid", 0);
      walk(32'h0040_5000, root_a, "R6 L2 invalid", 0);
      walk(32'hFFFF_F777, root_a, "R2 max idx1", 0);
      walk(32'h0020_0000, root_b, "R2 root wrap", 0);
      lat_cfg = 5; stall_cfg = 3;
      walk(32'h0040_3ABC, root_a, "R8 stall+latency", 0);
      walk(32'h0080_0001, root_a, "R8 R5 slow fault", 0);
      lat_cfg = 3; stall_cfg = 1;
      walk(32'h007F_F00C, root_a, "R9 ignored req", 1);
      lat_cfg = 0; stall_cfg = 0;
      walk(32'h0040_3001, root_a, "R4 back to back", 0);

      chk("R5 no leftover reads", 64'(addr_q.size()), 64'd0);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule